// File: doc/BRIEF.md
# Posted-Write Acknowledgment Tracker

This block sits beside an outgoing request path and keeps account of posted writes that are still waiting for their acknowledgment. Every cycle it looks at the header-valid strobe and the 7-bit command of the packet leaving the sender. Two command codes are treated as posted writes: write-invalidate and write-merge. When one of them goes out, the block records the packet's 16-bit tag and the cycle it was issued in a small first-in, first-out store. A returning acknowledgment pulse always retires the oldest recorded write.

The sender reads the outstanding count and a credit signal from this block. The credit signal stops it from issuing more posted writes than the store can hold. Five sticky error flags report protocol violations:

- an acknowledgment that arrives too soon;
- a write that waits too long for its acknowledgment;
- an acknowledgment that arrives when no write is pending;
- a write issued without credit;
- an acknowledgment whose tag does not match the oldest write.

The flags stay set until a synchronous clear pulse or reset.

Top module: `pw_ack_tracker`

## Requirements
- R1: A header with `hdr_vld` high and `hdr_cmd` equal to 7'b0100100 (write-invalidate) or 7'b0101100 (write-merge) is recorded. `outstanding` is one higher after that clock edge, unless an acknowledgment retires an entry on the same edge.
- R2: A header with any other command value is ignored. It changes neither `outstanding` nor any error flag.
- R3: Each `ack_vld` pulse retires the oldest recorded write, in issue order, and `outstanding` drops by one. If `ack_tag` differs from that write's tag, `err_tag_mismatch` is set and the entry is still retired.
- R4: An `ack_vld` pulse while `outstanding` is 0 sets `err_unsolicited` and retires nothing.
- R5: The age of a write is the number of clock edges from the edge that sampled its header to the edge that samples its acknowledgment. An acknowledgment at an age below 2 sets `err_early`, and the entry is still retired.
- R6: `err_timeout` is set on the first edge at which the oldest outstanding write has an age above 48000. An acknowledgment at age exactly 48000 does not set it.
- R7: `outstanding` never exceeds 16, and `credit_ok` is low exactly while 16 writes are outstanding.
- R8: A posted-write header that arrives while `credit_ok` is low sets `err_overflow` and is not recorded.
- R9: Every error flag stays set until `clr_err` is sampled high. If a new error event occurs on the same edge as the clear, the flag stays set.
- R10: After reset, `outstanding` is 0, `credit_ok` is 1 and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_err | input | 1 | Synchronous clear of all error flags |
| hdr_vld | input | 1 | Outgoing header strobe |
| hdr_cmd | input | 7 | Outgoing command code |
| hdr_tag | input | 16 | Outgoing transaction tag |
| ack_vld | input | 1 | Acknowledgment pulse |
| ack_tag | input | 16 | Tag carried with the acknowledgment |
| outstanding | output | 5 | Number of unacknowledged posted writes |
| credit_ok | output | 1 | Room for another posted write |
| err_early | output | 1 | Sticky: acknowledgment at age below 2 |
| err_timeout | output | 1 | Sticky: oldest write older than 48000 |
| err_unsolicited | output | 1 | Sticky: acknowledgment with nothing outstanding |
| err_overflow | output | 1 | Sticky: posted write issued without credit |
| err_tag_mismatch | output | 1 | Sticky: acknowledgment tag differs from oldest entry |

## Verification
The timeout boundary is the hardest case to reach from the ports. It needs a single write to sit unanswered for tens of thousands of cycles, and the acknowledgment must then land on exactly age 48000 or 48001. The stimulus issues one write, idles for a computed number of cycles, and then acknowledges it. This is done once at the last legal age and once a cycle too late. A behavioural queue model tracks issue cycles and is compared with every output on every clock. Directed sequences fill the store to its limit, retire entries out of tag order, and collide a clear pulse with a fresh error.

// File: rtl/pw_ack_tracker.sv
module pw_ack_tracker #(
  parameter int DEPTH   = 16,
  parameter int TAG_W   = 16,
  parameter int CMD_W   = 7,
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 48000,
  parameter logic [CMD_W-1:0] CMD_WR_INV = 7'b0100100,
  parameter logic [CMD_W-1:0] CMD_WR_MRG = 7'b0101100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_err,
  input  logic                     hdr_vld,
  input  logic [CMD_W-1:0]         hdr_cmd,
  input  logic [TAG_W-1:0]         hdr_tag,
  input  logic                     ack_vld,
  input  logic [TAG_W-1:0]         ack_tag,
  output logic [$clog2(DEPTH+1)-1:0] outstanding,
  output logic                     credit_ok,
  output logic                     err_early,
  output logic                     err_timeout,
  output logic                     err_unsolicited,
  output logic                     err_overflow,
  output logic                     err_tag_mismatch
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int TS_W  = $clog2(MAX_LAT+1) + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);
  localparam logic [TS_W-1:0]  MAX_AGE  = TS_W'(MAX_LAT);
  localparam logic [TS_W-1:0]  MIN_AGE  = TS_W'(MIN_LAT);

  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TS_W-1:0]  ts_q  [DEPTH];
  logic [DEPTH-1:0] live_q, late_q;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic [TS_W-1:0]  now_q;

  logic is_wr, empty, full, push, pop, head_late;
  logic ev_early, ev_to, ev_un, ev_ov, ev_mm;
  logic [TS_W-1:0] head_age;

  assign is_wr     = hdr_vld && (hdr_cmd == CMD_WR_INV || hdr_cmd == CMD_WR_MRG);
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == FULL_CNT);
  assign push      = is_wr && !full;
  assign pop       = ack_vld && !empty;
  assign head_age  = now_q - ts_q[rd_ptr];
  assign head_late = !empty && (late_q[rd_ptr] || head_age > MAX_AGE);

  assign ev_to    = head_late;
  assign ev_early = pop && !head_late && (head_age < MIN_AGE);
  assign ev_mm    = pop && (ack_tag != tag_q[rd_ptr]);
  assign ev_un    = ack_vld && empty;
  assign ev_ov    = is_wr && full;

  assign outstanding = cnt_q;
  assign credit_ok   = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      late_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0;
        ts_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && wr_ptr == PTR_W'(i)) begin
          live_q[i] <= 1'b1;
          late_q[i] <= 1'b0;
          tag_q[i]  <= hdr_tag;
          ts_q[i]   <= now_q;
        end else if (pop && rd_ptr == PTR_W'(i)) begin
          live_q[i] <= 1'b0;
          late_q[i] <= 1'b0;
        end else if (live_q[i] && (now_q - ts_q[i]) > MAX_AGE) begin
          late_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_early        <= 1'b0;
      err_timeout      <= 1'b0;
      err_unsolicited  <= 1'b0;
      err_overflow     <= 1'b0;
      err_tag_mismatch <= 1'b0;
    end else begin
      err_early        <= (err_early        && !clr_err) || ev_early;
      err_timeout      <= (err_timeout      && !clr_err) || ev_to;
      err_unsolicited  <= (err_unsolicited  && !clr_err) || ev_un;
      err_overflow     <= (err_overflow     && !clr_err) || ev_ov;
      err_tag_mismatch <= (err_tag_mismatch && !clr_err) || ev_mm;
    end
  end
endmodule

// File: rtl/pw_ack_tracker_chk.sv
module pw_ack_tracker_chk #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 16,
  parameter int CMD_W = 7,
  parameter logic [CMD_W-1:0] CMD_WR_INV = 7'b0100100,
  parameter logic [CMD_W-1:0] CMD_WR_MRG = 7'b0101100
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clr_err,
  input logic                       hdr_vld,
  input logic [CMD_W-1:0]           hdr_cmd,
  input logic                       ack_vld,
  input logic [$clog2(DEPTH+1)-1:0] outstanding,
  input logic                       credit_ok,
  input logic                       err_early,
  input logic                       err_timeout,
  input logic                       err_unsolicited,
  input logic                       err_overflow,
  input logic                       err_tag_mismatch
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic wr_hdr;
  assign wr_hdr = hdr_vld && (hdr_cmd == CMD_WR_INV || hdr_cmd == CMD_WR_MRG);

  AST_WRITE_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hdr && credit_ok && !ack_vld) |=> (outstanding == $past(outstanding) + 1'b1)); // R1
  AST_OTHER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hdr && !ack_vld) |=> $stable(outstanding)); // R2
  AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && outstanding != '0 && !wr_hdr) |=> (outstanding == $past(outstanding) - 1'b1)); // R3
  AST_UNSOLICITED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && outstanding == '0) |=> err_unsolicited); // R4
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= FULL_CNT); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hdr && !credit_ok) |=> (err_overflow && $stable(outstanding) || ack_vld)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_timeout && !clr_err) |=> err_timeout); // R9
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !ack_vld && !hdr_vld && outstanding == '0) |=>
      !(err_early || err_timeout || err_unsolicited || err_overflow || err_tag_mismatch)); // R9
endmodule

bind pw_ack_tracker pw_ack_tracker_chk #(
  .DEPTH(DEPTH), .TAG_W(TAG_W), .CMD_W(CMD_W),
  .CMD_WR_INV(CMD_WR_INV), .CMD_WR_MRG(CMD_WR_MRG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .hdr_vld(hdr_vld), .hdr_cmd(hdr_cmd),
  .ack_vld(ack_vld), .outstanding(outstanding), .credit_ok(credit_ok),
  .err_early(err_early), .err_timeout(err_timeout), .err_unsolicited(err_unsolicited),
  .err_overflow(err_overflow), .err_tag_mismatch(err_tag_mismatch)
);

// File: tb/pw_ack_tracker_test.sv
module pw_ack_tracker_test;
  localparam int DEPTH = 16;
  localparam int MAXL  = 48000;
  localparam logic [6:0] WINV = 7'b0100100;
  localparam logic [6:0] WMRG = 7'b0101100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr, hv, av;
  logic [6:0] cmd;
  logic [15:0] tg, atg;
  logic [4:0] outstanding;
  logic credit_ok, e_early, e_to, e_un, e_ov, e_mm;

  always #2.5 clk = ~clk;

  pw_ack_tracker uut (
    .clk(clk), .rst_n(rst_n), .clr_err(clr), .hdr_vld(hv), .hdr_cmd(cmd), .hdr_tag(tg),
    .ack_vld(av), .ack_tag(atg), .outstanding(outstanding), .credit_ok(credit_ok),
    .err_early(e_early), .err_timeout(e_to), .err_unsolicited(e_un),
    .err_overflow(e_ov), .err_tag_mismatch(e_mm)
  );

  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, string what, longint got, longint exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // behavioural reference model
  int     q_tag[$];
  longint q_t[$];
  longint mcyc;
  bit m_early, m_to, m_un, m_ov, m_mm;
  bit n_early, n_to, n_un, n_ov, n_mm, wasfull;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_tag.delete(); q_t.delete(); mcyc = 0;
      m_early = 0; m_to = 0; m_un = 0; m_ov = 0; m_mm = 0;
    end else begin
      n_early = 0; n_to = 0; n_un = 0; n_ov = 0; n_mm = 0;
      wasfull = (q_tag.size() == DEPTH);
      if (q_tag.size() > 0 && (mcyc - q_t[0]) > MAXL) n_to = 1;
      if (av) begin
        if (q_tag.size() == 0) n_un = 1;
        else begin
          if ((mcyc - q_t[0]) < 2) n_early = 1;
          if (q_tag[0] != int'(atg)) n_mm = 1;
          void'(q_tag.pop_front()); void'(q_t.pop_front());
        end
      end
      if (hv && (cmd == WINV || cmd == WMRG)) begin
        if (wasfull) n_ov = 1;
        else begin q_tag.push_back(int'(tg)); q_t.push_back(mcyc); end
      end
      m_early = (m_early && !clr) || n_early;
      m_to    = (m_to    && !clr) || n_to;
      m_un    = (m_un    && !clr) || n_un;
      m_ov    = (m_ov    && !clr) || n_ov;
      m_mm    = (m_mm    && !clr) || n_mm;
      mcyc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1", "outstanding", outstanding, q_tag.size());
      chk("R7", "credit_ok", credit_ok, q_tag.size() < DEPTH);
      chk("R5", "err_early", e_early, m_early);
      chk("R6", "err_timeout", e_to, m_to);
      chk("R4", "err_unsolicited", e_un, m_un);
      chk("R8", "err_overflow", e_ov, m_ov);
      chk("R3", "err_tag_mismatch", e_mm, m_mm);
    end
  end

  task automatic drive(logic h, logic [6:0] c, logic [15:0] t, logic a, logic [15:0] at, logic cl);
    @(negedge clk);
    hv = h; cmd = c; tg = t; av = a; atg = at; clr = cl;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 7'd0, 16'd0, 0, 16'd0, 0);
  endtask
  task automatic wr(logic [6:0] c, logic [15:0] t); drive(1, c, t, 0, 16'd0, 0); endtask
  task automatic ack(logic [15:0] t); drive(0, 7'd0, 16'd0, 1, t, 0); endtask

  function automatic int flags();
    return {27'd0, e_early, e_to, e_un, e_ov, e_mm};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    hv = 0; cmd = 0; tg = 0; av = 0; atg = 0; clr = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10", "reset outstanding", outstanding, 0);
    chk("R10", "reset credit", credit_ok, 1);
    chk("R10", "reset flags", flags(), 0);
    rst_n = 1;
    idle(2);

    // R2: non-posted command codes are ignored
    wr(7'b0010100, 16'h0001); wr(7'b0000010, 16'h0002); wr(7'b0100101, 16'h0003);
    wr(7'b1010011, 16'h0004); idle(1);
    chk("R2", "ignored cmd count", outstanding, 0);
    chk("R2", "ignored cmd flags", flags(), 0);

    // R1: both posted commands counted
    wr(WINV, 16'h0011); idle(1);
    chk("R1", "after write-invalidate", outstanding, 1);
    wr(WMRG, 16'h0022); idle(1);
    chk("R1", "after write-merge", outstanding, 2);
    ack(16'h0011); ack(16'h0022); idle(1);
    chk("R3", "in-order drain", outstanding, 0);
    chk("R3", "no flags after clean drain", flags(), 0);

    // R5: age 1 is early, age 2 is legal
    wr(WINV, 16'h0031); ack(16'h0031); idle(1);
    chk("R5", "early ack flagged", e_early, 1);
    drive(0, 7'd0, 16'd0, 0, 16'd0, 1); idle(1);
    chk("R9", "clear early", e_early, 0);
    wr(WINV, 16'h0032); idle(1); ack(16'h0032); idle(1);
    chk("R5", "age 2 not early", e_early, 0);

    // R3: out-of-order tag retires the oldest and flags mismatch
    wr(WINV, 16'h0041); wr(WMRG, 16'h0042); idle(3);
    ack(16'h0042); idle(1);
    chk("R3", "mismatch flagged", e_mm, 1);
    chk("R3", "entry retired", outstanding, 1);
    ack(16'h0042); idle(1);
    chk("R3", "second ack matches", outstanding, 0);

    // R4 and R9 collision: clear and unsolicited on the same edge
    ack(16'h0099); idle(1);
    chk("R4", "unsolicited", e_un, 1);
    chk("R4", "count stays 0", outstanding, 0);
    drive(0, 7'd0, 16'd0, 1, 16'h0099, 1); idle(1);
    chk("R9", "new event beats clear", e_un, 1);
    drive(0, 7'd0, 16'd0, 0, 16'd0, 1); idle(1);
    chk("R9", "all flags cleared", flags(), 0);

    // R7 / R8: fill to the limit, then one more
    for (int i = 0; i < DEPTH; i++) wr((i % 2) ? WMRG : WINV, 16'h0100 + 16'(i));
    idle(1);
    chk("R7", "full count", outstanding, DEPTH);
    chk("R7", "credit low at full", credit_ok, 0);
    wr(WINV, 16'h01FF); idle(1);
    chk("R8", "overflow flagged", e_ov, 1);
    chk("R8", "overflow not recorded", outstanding, DEPTH);
    for (int i = 0; i < DEPTH; i++) ack(16'h0100 + 16'(i));
    idle(1);
    chk("R7", "drained", outstanding, 0);
    chk("R3", "fill order kept", e_mm, 0);
    drive(0, 7'd0, 16'd0, 0, 16'd0, 1); idle(1);

    // R6: acknowledgment at the last legal age
    wr(WINV, 16'h0500); idle(MAXL - 1); ack(16'h0500); idle(1);
    chk("R6", "age limit exact", e_to, 0);
    // R6: one cycle past the limit
    wr(WMRG, 16'h0501); idle(MAXL); idle(1);
    chk("R6", "not yet at limit", e_to, 0);
    idle(1);
    chk("R6", "timeout flagged", e_to, 1);
    chk("R6", "entry kept", outstanding, 1);
    ack(16'h0501); idle(2);
    chk("R9", "timeout sticky", e_to, 1);
    chk("R5", "late ack not early", e_early, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule